// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial characters from a single line. It runs on the system clock and advances only on a one-cycle tick at sixteen times the bit rate. A character can carry seven or eight data bits, sent least significant bit first. An even or odd parity bit may follow the data, and one or two stop bits close the character. The receiver finds the start bit, takes each bit by a majority of three mid-bit samples, and builds the character in a shift register. When the last stop bit ends, the character moves into a holding buffer.

Overrun, framing and parity errors are all judged at that move into the buffer. Each error sets a sticky flag, and a summary flag is raised while any of the three is set. The buffer has no back-pressure. The buffer-full flag acts as a valid, and the low-byte read strobe acts as a one-cycle ready that empties the buffer. If a new character completes while the buffer is still full, it overwrites the buffer and raises overrun, and no new receive request is issued. The read strobe clears the framing and parity flags but leaves overrun set. Turning the receiver off clears every flag. The receiver is off when the enable is low or when the mode field is 000.

Top module: `async_rx_errs`

## Requirements
- R1: An 8-bit character (cfg_len8=1) arrives least significant bit first. It appears on rx_data with buf_full=1 and a single-cycle rx_req pulse, one clock after its last stop bit ends.
- R2: With cfg_len8=0, seven data bits are received into rx_data[6:0] and rx_data[7] reads 0.
- R3: With cfg_par_en=1, one parity bit follows the last data bit. Even parity is selected by cfg_par_odd=0 and odd parity by cfg_par_odd=1. err_par is set when the number of ones in the data bits plus the parity bit is odd for even parity, or even for odd parity.
- R4: err_frm is set when any stop bit is sampled low. The receiver expects two stop bits when cfg_stop2=1 and one when cfg_stop2=0.
- R5: If a character completes while buf_full=1 and rd_lo is not high in that cycle, err_ovr is set and rx_data takes the new character. No rx_req pulse is produced for it.
- R6: A one-cycle rd_lo pulse clears buf_full, err_frm and err_par on the next clock. It leaves err_ovr unchanged.
- R7: err_sum is high while any of err_ovr, err_frm or err_par is high, and it falls only once all three are low.
- R8: When rx_en=0 or cfg_mode=3'b000, all three error flags and buf_full are cleared. While the receiver is off, no character is received.
- R9: A start bit is accepted only when at least two of samples 7, 8 and 9 (counted from the detected falling edge as sample 0) are low. A shorter low pulse produces no character. Every data, parity and stop bit is taken by the same vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable; low clears flags |
| cfg_mode | input | 3 | Mode field; 000 turns the receiver off and clears flags |
| cfg_len8 | input | 1 | 1 = eight data bits, 0 = seven |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| rd_lo | input | 1 | Read strobe of the buffer low byte |
| rx_data | output | 8 | Received character |
| buf_full | output | 1 | Buffer holds an unread character |
| rx_req | output | 1 | Receive request pulse, one cycle |
| err_ovr | output | 1 | Overrun flag |
| err_frm | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |

## Verification
A character's data and flags become valid one clock after the tick that ends its last stop bit. The line passes through a two-stage synchronizer, and the edge is first seen on a tick, so the end of a frame can be late by up to about six clocks. For that reason the bench holds the line idle for 32 clocks after each frame before it samples, and no other character is in flight during that time. The effects of a read strobe or a clear are due on the next clock, and the bench samples them at the following falling edge. rx_req pulses are counted at every rising edge, so a missing or extra request shows up as a wrong count rather than depending on when the bench samples.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_st_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/rxe_sync.sv
module rxe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxe_framer.sv
module rxe_framer
  import rxe_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          line,
  input  logic          len_full,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop2,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          frm_err,
  output logic          par_err
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW);
  localparam int MID = OVS / 2;

  rx_st_t        st;
  logic [CW-1:0] cnt;
  logic [2:0]    votes;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          pbit;
  logic          sbad;
  logic          stopn;
  logic          v;
  logic [BW-1:0] last_idx;

  assign v        = maj3(votes);
  assign last_idx = len_full ? BW'(DW - 1) : BW'(DW - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      votes   <= '1;
      bidx    <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      sbad    <= 1'b0;
      stopn   <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        st <= ST_IDLE;
      end else if (tick) begin
        if (st == ST_IDLE) begin
          if (!line) begin
            st  <= ST_START;
            cnt <= CW'(1);
          end
        end else begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(MID - 1)) votes[0] <= line;
          if (cnt == CW'(MID))     votes[1] <= line;
          if (cnt == CW'(MID + 1)) votes[2] <= line;
          if (cnt == CW'(OVS - 1)) begin
            cnt <= '0;
            case (st)
              ST_START: begin
                if (!v) begin
                  st    <= ST_DATA;
                  bidx  <= '0;
                  shreg <= '0;
                  sbad  <= 1'b0;
                  stopn <= 1'b0;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_DATA: begin
                shreg[bidx] <= v;
                if (bidx == last_idx) st <= par_en ? ST_PAR : ST_STOP;
                else                  bidx <= bidx + BW'(1);
              end
              ST_PAR: begin
                pbit <= v;
                st   <= ST_STOP;
              end
              ST_STOP: begin
                if (stop2 && !stopn) begin
                  stopn <= 1'b1;
                  sbad  <= sbad | ~v;
                end else begin
                  done    <= 1'b1;
                  data    <= shreg;
                  frm_err <= sbad | ~v;
                  par_err <= par_en && ((^shreg ^ pbit) != par_odd);
                  st      <= ST_IDLE;
                end
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxe_holdreg.sv
module rxe_holdreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          done,
  input  logic [DW-1:0] din,
  input  logic          frm_in,
  input  logic          par_in,
  input  logic          rd_lo,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          req,
  output logic          ovr,
  output logic          frm,
  output logic          par
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      full <= 1'b0;
      req  <= 1'b0;
      ovr  <= 1'b0;
      frm  <= 1'b0;
      par  <= 1'b0;
    end else begin
      req <= 1'b0;
      if (clr) begin
        full <= 1'b0;
        ovr  <= 1'b0;
        frm  <= 1'b0;
        par  <= 1'b0;
      end else begin
        if (rd_lo) begin
          full <= 1'b0;
          frm  <= 1'b0;
          par  <= 1'b0;
        end
        if (done) begin
          dout <= din;
          full <= 1'b1;
          if (full && !rd_lo) ovr <= 1'b1;
          else                req <= 1'b1;
          if (frm_in) frm <= 1'b1;
          if (par_in) par <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/async_rx_errs.sv
module async_rx_errs #(
  parameter int OVS        = 16,
  parameter int DW         = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_len8,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  input  logic          rd_lo,
  output logic [DW-1:0] rx_data,
  output logic          buf_full,
  output logic          rx_req,
  output logic          err_ovr,
  output logic          err_frm,
  output logic          err_par,
  output logic          err_sum
);
  logic          line_s;
  logic          clr;
  logic          f_done;
  logic [DW-1:0] f_data;
  logic          f_frm;
  logic          f_par;

  assign clr = !rx_en || (cfg_mode == 3'b000);

  rxe_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  rxe_framer #(.OVS(OVS), .DW(DW)) u_framer (
    .clk(clk), .rst_n(rst_n), .run(!clr), .tick(tick16), .line(line_s),
    .len_full(cfg_len8), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .stop2(cfg_stop2), .done(f_done), .data(f_data),
    .frm_err(f_frm), .par_err(f_par)
  );

  rxe_holdreg #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr), .done(f_done), .din(f_data),
    .frm_in(f_frm), .par_in(f_par), .rd_lo(rd_lo), .dout(rx_data),
    .full(buf_full), .req(rx_req), .ovr(err_ovr), .frm(err_frm), .par(err_par)
  );

  assign err_sum = err_ovr | err_frm | err_par;
endmodule

// File: rtl/async_rx_errs_chk.sv
module async_rx_errs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic [2:0] cfg_mode,
  input logic       rd_lo,
  input logic       buf_full,
  input logic       rx_req,
  input logic       err_ovr,
  input logic       err_frm,
  input logic       err_par,
  input logic       err_sum
);
  // R5
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> $past(buf_full));

  // R1
  req_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> buf_full);

  // R1
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |=> !rx_req);

  // R5
  no_req_on_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (!$past(buf_full) || $past(rd_lo)));

  // R6
  read_keeps_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovr && rd_lo && rx_en && cfg_mode != 3'b000) |=> err_ovr);

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rx_req && !$rose(buf_full)) |=> (!err_frm && !err_par) || buf_full);

  // R8
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || cfg_mode == 3'b000) |=> (!err_ovr && !err_frm && !err_par && !buf_full));

  // R7
  sum_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_sum) |-> (!err_ovr && !err_frm && !err_par));
endmodule

bind async_rx_errs async_rx_errs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_mode(cfg_mode), .rd_lo(rd_lo),
  .buf_full(buf_full), .rx_req(rx_req), .err_ovr(err_ovr), .err_frm(err_frm),
  .err_par(err_par), .err_sum(err_sum)
);

// File: tb/tb_async_rx_errs.sv
module tb_async_rx_errs;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b1;
  logic [2:0] cfg_mode = 3'b101;
  logic       cfg_len8 = 1'b1;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       rd_lo = 1'b0;
  logic [7:0] rx_data;
  logic       buf_full, rx_req, err_ovr, err_frm, err_par, err_sum;

  int nchk = 0;
  int nbad = 0;
  int nreq = 0;
  int tdiv = 0;
  bit finished = 0;

  async_rx_errs dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .cfg_mode(cfg_mode), .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .rd_lo(rd_lo),
    .rx_data(rx_data), .buf_full(buf_full), .rx_req(rx_req), .err_ovr(err_ovr),
    .err_frm(err_frm), .err_par(err_par), .err_sum(err_sum)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == TDIV - 1);
    if (rst_n && rx_req) nreq <= nreq + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pe,
                      input logic pb, input int ns, input logic s1, input logic s2);
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(d[i]);
    if (pe) hold_bit(pb);
    hold_bit(s1);
    if (ns == 2) hold_bit(s2);
    rxd = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic read_lo();
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset buf_full", buf_full, 0);
    check("R7 reset err_sum", err_sum, 0);
    check("R5 reset err_ovr", err_ovr, 0);
    check("R1 reset req count", nreq, 0);
  endtask

  task automatic t_plain8();
    int r0 = nreq;
    cfg_len8 = 1; cfg_par_en = 0; cfg_stop2 = 0;
    send(8'hA5, 8, 0, 0, 1, 1, 1);
    check("R1 data", rx_data, 8'hA5);
    check("R1 full", buf_full, 1);
    check("R1 one req", nreq - r0, 1);
    check("R4 no frm", err_frm, 0);
    read_lo();
    check("R6 read empties", buf_full, 0);
    send(8'h3C, 8, 0, 0, 1, 1, 1);
    check("R1 data 3C", rx_data, 8'h3C);
    read_lo();
  endtask

  task automatic t_len7();
    cfg_len8 = 0;
    send(8'hDA, 7, 0, 0, 1, 1, 1);
    check("R2 seven bits", rx_data, 8'h5A);
    read_lo();
    cfg_len8 = 1;
  endtask

  task automatic t_parity();
    cfg_par_en = 1; cfg_par_odd = 0;
    send(8'h3B, 8, 1, ^8'h3B, 1, 1, 1);
    check("R3 even ok", err_par, 0);
    check("R3 even ok data", rx_data, 8'h3B);
    read_lo();
    send(8'h3B, 8, 1, ~^8'h3B, 1, 1, 1);
    check("R3 even bad", err_par, 1);
    check("R7 sum on par", err_sum, 1);
    read_lo();
    check("R6 par cleared", err_par, 0);
    check("R7 sum drops", err_sum, 0);
    cfg_par_odd = 1;
    send(8'h01, 8, 1, 1'b0, 1, 1, 1);
    check("R3 odd ok", err_par, 0);
    read_lo();
    send(8'h01, 8, 1, 1'b1, 1, 1, 1);
    check("R3 odd bad", err_par, 1);
    read_lo();
    cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_frame();
    cfg_stop2 = 1;
    send(8'h66, 8, 0, 0, 2, 1, 1);
    check("R4 two stops ok", err_frm, 0);
    read_lo();
    send(8'h66, 8, 0, 0, 2, 1, 0);
    check("R4 second stop low", err_frm, 1);
    check("R7 sum on frm", err_sum, 1);
    read_lo();
    check("R6 frm cleared", err_frm, 0);
    cfg_stop2 = 0;
    send(8'h77, 8, 0, 0, 1, 0, 1);
    check("R4 single stop low", err_frm, 1);
    read_lo();
  endtask

  task automatic t_overrun();
    int r0 = nreq;
    send(8'h11, 8, 0, 0, 1, 1, 1);
    send(8'h22, 8, 0, 0, 1, 1, 1);
    check("R5 overwritten", rx_data, 8'h22);
    check("R5 ovr set", err_ovr, 1);
    check("R5 one req only", nreq - r0, 1);
    read_lo();
    check("R6 ovr kept", err_ovr, 1);
    check("R6 full cleared", buf_full, 0);
    check("R7 sum held", err_sum, 1);
    rx_en = 0;
    @(negedge clk);
    @(negedge clk);
    check("R8 en clears ovr", err_ovr, 0);
    check("R7 sum after clear", err_sum, 0);
    rx_en = 1;
    @(negedge clk);
  endtask

  task automatic t_mode_clear();
    cfg_par_en = 1;
    send(8'h0F, 8, 1, 1'b1, 1, 1, 1);
    check("R3 setup par err", err_par, 1);
    cfg_mode = 3'b000;
    @(negedge clk);
    @(negedge clk);
    check("R8 mode clears par", err_par, 0);
    check("R8 mode clears full", buf_full, 0);
    cfg_mode = 3'b101;
    cfg_par_en = 0;
    @(negedge clk);
  endtask

  task automatic t_false_start();
    int r0 = nreq;
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (20 * BITCLK) @(negedge clk);
    check("R9 glitch no full", buf_full, 0);
    check("R9 glitch no req", nreq - r0, 0);
    send(8'h5C, 8, 0, 0, 1, 1, 1);
    check("R9 after glitch data", rx_data, 8'h5C);
    read_lo();
  endtask

  task automatic t_disabled();
    int r0 = nreq;
    rx_en = 0;
    send(8'h99, 8, 0, 0, 1, 1, 1);
    check("R8 off no full", buf_full, 0);
    check("R8 off no req", nreq - r0, 0);
    rx_en = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_plain8();
    t_len7();
    t_parity();
    t_frame();
    t_overrun();
    t_mode_clear();
    t_false_start();
    t_disabled();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule